// File: doc/BRIEF.md
# Mixed-width halfword register bank

This block is a bank of 16-bit control registers in a 4 KB address window. A host bus reaches it with 8-, 16- and 32-bit accesses. Only the low 12 address bits are decoded, so the upper bits choose where the window sits in the system map and never reach the bank. Every access becomes one or two halfword operations on the bank. A 32-bit access is split into an upper and a lower halfword. An 8-bit read picks one byte out of the halfword that contains it. An 8-bit write is refused.

Most registers are plain storage. Several act on write:

- Four framebuffer-address registers can clear their page-offset field.
- Four display-interrupt registers pulse a strobe that tells the interrupt logic to re-evaluate.
- The control register accepts only a subset of its bits.
- The two beam-position registers are read-only views of inputs.
- A 32-bit register seen as two halfwords is updated by masked merge.

An unmapped read returns zero and flags an error.

A request is presented for one cycle. The host then waits for `rsp_ready` before it presents the next request. Requests that arrive during the second phase of a 32-bit access are ignored.

Top module: `hwreg_bank`

## Requirements
- R1: After reset every stored register reads 0, and `rsp_ready` and `irq_update` are 0.
- R2: A 16-bit access (`req_size`=2) writes or reads the halfword at offset `addr[11:1]`. `rsp_ready` is high in the cycle after the request, with read data on `rsp_rdata[15:0]` and zero in the upper bits. The general registers sit at offsets 0x050 + 2·i, i = 0..7.
- R3: A 32-bit access (`req_size`=4) at offset A moves bits 31:16 to A and bits 15:0 to A+2. `rsp_ready` rises two cycles after the request.
- R4: An 8-bit read (`req_size`=1) at an even address returns bits 15:8 of that halfword. At an odd address it returns bits 7:0 of the halfword at the even address below. Both are zero-extended.
- R5: An 8-bit write changes no register. It still completes with `rsp_ready`.
- R6: The framebuffer-address registers have their upper halves at 0x010 + 4·k and their lower halves at 0x012 + 4·k, k = 0..3. An upper-half write stores the value. If bit 12 of the value (clear flag) is 1, bits 11:8 (page offset) are stored as 0.
- R7: The display-interrupt registers have their upper halves at 0x020 + 4·k and their lower halves at 0x022 + 4·k. An upper-half write stores the value and raises `irq_update` for exactly one cycle. A lower-half write stores the value without the strobe.
- R8: Reads of offset 0x030 return `beam_v` and reads of 0x032 return `beam_h`. Writes to either offset have no effect.
- R9: A write to the control register at 0x000 updates only bits 0, 2, 3, 8 and 9 (mask 0x030D). All other bits keep their value.
- R10: The 32-bit register has its upper half at 0x040 and its lower half at 0x042. A write to 0x040 replaces bits 31:16 only, and a write to 0x042 replaces bits 15:0 only.
- R11: A read of an unmapped offset returns 0 and raises `rsp_err` together with `rsp_ready`. A write to an unmapped offset is dropped. Mapped reads leave `rsp_err` at 0.
- R12: Address bits 31:12 are ignored, so any window base reaches the same registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| req_addr | input | 32 | Byte address; low 12 bits decoded |
| req_wdata | input | 32 | Write data, right-aligned for 16-bit accesses |
| beam_v | input | 16 | Current vertical beam position |
| beam_h | input | 16 | Current horizontal beam position |
| rsp_ready | output | 1 | Access complete, one-cycle pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` |
| rsp_err | output | 1 | Unmapped read, valid with `rsp_ready` |
| irq_update | output | 1 | One-cycle interrupt re-evaluation strobe |

## Verification
The assertions watch the following on every cycle:
- a 32-bit request goes through a second phase before it completes;
- a narrower request completes in the next cycle;
- a stored framebuffer register never holds its clear flag together with a non-zero page offset;
- control bits outside the write mask stay zero;
- the interrupt strobe only follows a halfword write;
- the error flag only appears with a completion.

Byte-lane selection, the order of the two halves of a 32-bit access, masked merging, ignored byte and beam writes, and address aliasing are data-dependent. Only the bench's scenarios show them, through read-back values at the ports.

// File: rtl/hwreg_pkg.sv
// Shared constants, types and helpers for the halfword register bank.
// Assumes a 4 KB window decoded on the low OFS_W address bits.
package hwreg_pkg;
    localparam int BUS_AW = 32;
    localparam int BUS_DW = 32;
    localparam int REG_W  = 16;
    localparam int OFS_W  = 12;
    localparam int HIDX_W = OFS_W - 1;
    localparam int N_FB   = 4;
    localparam int N_INT  = 4;

    localparam logic [2:0] SZ_BYTE = 3'd1;
    localparam logic [2:0] SZ_WORD = 3'd4;

    localparam logic [OFS_W-1:0] CTRL_OFS   = 12'h000;
    localparam logic [OFS_W-1:0] FB_BASE    = 12'h010;
    localparam logic [OFS_W-1:0] INT_BASE   = 12'h020;
    localparam logic [OFS_W-1:0] VBEAM_OFS  = 12'h030;
    localparam logic [OFS_W-1:0] HBEAM_OFS  = 12'h032;
    localparam logic [OFS_W-1:0] WIDE_OFS   = 12'h040;
    localparam logic [OFS_W-1:0] PLAIN_BASE = 12'h050;

    localparam logic [REG_W-1:0] CTRL_WMASK = 16'h030D;
    localparam int FB_CLR_BIT  = 12;
    localparam int FB_POFF_LSB = 8;
    localparam int FB_POFF_W   = 4;

    // One halfword operation presented to the register store.
    typedef struct packed {
        logic              valid;
        logic              write;
        logic [HIDX_W-1:0] hidx;
        logic [REG_W-1:0]  wdata;
    } hw_op_t;

    // Value stored on a framebuffer upper-half write.
    function automatic logic [REG_W-1:0] fb_store(input logic [REG_W-1:0] v);
        logic [REG_W-1:0] r;
        r = v;
        if (v[FB_CLR_BIT]) r[FB_POFF_LSB +: FB_POFF_W] = '0;
        return r;
    endfunction
endpackage

// File: rtl/hwreg_seq.sv
// Access sequencer: turns 8/16/32-bit bus requests into halfword operations
// and builds the registered response. A 32-bit access takes a second phase
// for the lower half. Assumes the host waits for rsp_ready before the next
// request; requests during the second phase are ignored.
module hwreg_seq
    import hwreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [2:0]        req_size_i,
    input  logic [BUS_AW-1:0] req_addr_i,
    input  logic [BUS_DW-1:0] req_wdata_i,
    input  logic [REG_W-1:0]  rd_data_i,
    input  logic              rd_hit_i,
    output hw_op_t            op_o,
    output logic              rsp_ready_o,
    output logic [BUS_DW-1:0] rsp_rdata_o,
    output logic              rsp_err_o
);
    logic              phase2_q;
    logic              p2_write_q;
    logic [HIDX_W-1:0] p2_hidx_q;
    logic [REG_W-1:0]  p2_wdata_q;
    logic [REG_W-1:0]  hi_keep_q;
    logic              hi_miss_q;
    logic              accept, is_word, is_byte;
    logic              addr_unused;

    assign accept      = req_valid_i && !phase2_q;
    assign is_word     = (req_size_i == SZ_WORD);
    assign is_byte     = (req_size_i == SZ_BYTE);
    assign addr_unused = ^req_addr_i[BUS_AW-1:OFS_W];

    // Select the halfword operation for this cycle.
    always_comb begin
        op_o = '0;
        if (phase2_q) begin
            op_o.valid = 1'b1;
            op_o.write = p2_write_q;
            op_o.hidx  = p2_hidx_q;
            op_o.wdata = p2_wdata_q;
        end else begin
            op_o.hidx  = req_addr_i[OFS_W-1:1];
            op_o.write = req_write_i;
            op_o.wdata = is_word ? req_wdata_i[BUS_DW-1:REG_W] : req_wdata_i[REG_W-1:0];
            op_o.valid = accept && !(req_write_i && is_byte);
        end
    end

    // Track the second phase and register the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase2_q    <= 1'b0;
            p2_write_q  <= 1'b0;
            p2_hidx_q   <= '0;
            p2_wdata_q  <= '0;
            hi_keep_q   <= '0;
            hi_miss_q   <= 1'b0;
            rsp_ready_o <= 1'b0;
            rsp_rdata_o <= '0;
            rsp_err_o   <= 1'b0;
        end else begin
            rsp_ready_o <= 1'b0;
            rsp_err_o   <= 1'b0;
            if (phase2_q) begin
                phase2_q    <= 1'b0;
                rsp_ready_o <= 1'b1;
                rsp_rdata_o <= p2_write_q ? '0 : {hi_keep_q, rd_data_i};
                rsp_err_o   <= !p2_write_q && (hi_miss_q || !rd_hit_i);
            end else if (accept) begin
                if (is_word) begin
                    phase2_q   <= 1'b1;
                    p2_write_q <= req_write_i;
                    p2_hidx_q  <= req_addr_i[OFS_W-1:1] + HIDX_W'(1);
                    p2_wdata_q <= req_wdata_i[REG_W-1:0];
                    hi_keep_q  <= rd_data_i;
                    hi_miss_q  <= !rd_hit_i;
                end else begin
                    rsp_ready_o <= 1'b1;
                    rsp_err_o   <= !req_write_i && !rd_hit_i;
                    if (req_write_i)
                        rsp_rdata_o <= '0;
                    else if (is_byte)
                        rsp_rdata_o <= {{(BUS_DW-8){1'b0}},
                                        req_addr_i[0] ? rd_data_i[7:0] : rd_data_i[15:8]};
                    else
                        rsp_rdata_o <= {{(BUS_DW-REG_W){1'b0}}, rd_data_i};
                end
            end
        end
    end

    AST_WORD_SECOND_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_word) |=> (phase2_q && !rsp_ready_o)) else $error("word phase"); // R3
    AST_HALF_READY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_word) |=> rsp_ready_o) else $error("half ready"); // R2
    AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_o |-> rsp_ready_o) else $error("err without ready"); // R11
endmodule

// File: rtl/hwreg_store.sv
// Register store: decodes one halfword operation per cycle, applies write
// side effects and returns combinational read data with a hit flag.
// Assumes op_i is stable for the whole cycle it is presented.
module hwreg_store
    import hwreg_pkg::*;
#(
    parameter int N_PLAIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  hw_op_t           op_i,
    input  logic [REG_W-1:0] beam_v_i,
    input  logic [REG_W-1:0] beam_h_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             rd_hit_o,
    output logic             irq_update_o
);
    logic [OFS_W-1:0]   ofs;
    logic               wr;
    logic [REG_W-1:0]   ctrl_q;
    logic [2*REG_W-1:0] wide_q;
    logic [REG_W-1:0]   fb_hi_w [N_FB];
    logic [REG_W-1:0]   fb_lo_w [N_FB];
    logic [REG_W-1:0]   int_hi_w[N_INT];
    logic [REG_W-1:0]   int_lo_w[N_INT];
    logic [REG_W-1:0]   plain_w [N_PLAIN];
    logic               int_hi_wr;

    assign ofs = {op_i.hidx, 1'b0};
    assign wr  = op_i.valid && op_i.write;

    // Control register: merge only the writable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (wr && ofs == CTRL_OFS)
            ctrl_q <= (ctrl_q & ~CTRL_WMASK) | (op_i.wdata & CTRL_WMASK);
    end

    // 32-bit register: each half replaces its own 16 bits.
    always_ff @(posedge clk) begin
        if (!rst_n) wide_q <= '0;
        else if (wr && ofs == WIDE_OFS) wide_q[2*REG_W-1:REG_W] <= op_i.wdata;
        else if (wr && ofs == WIDE_OFS + OFS_W'(2)) wide_q[REG_W-1:0] <= op_i.wdata;
    end

    for (genvar g = 0; g < N_FB; g++) begin : gen_fb
        logic [REG_W-1:0] hi_q, lo_q;
        // Framebuffer address pair with offset clear on the upper half.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q <= '0;
                lo_q <= '0;
            end else if (wr && ofs == OFS_W'(int'(FB_BASE) + 4*g)) hi_q <= fb_store(op_i.wdata);
            else if (wr && ofs == OFS_W'(int'(FB_BASE) + 4*g + 2)) lo_q <= op_i.wdata;
        end
        assign fb_hi_w[g] = hi_q;
        assign fb_lo_w[g] = lo_q;
        AST_FB_OFFSET_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            hi_q[FB_CLR_BIT] |-> (hi_q[FB_POFF_LSB +: FB_POFF_W] == '0)) else $error("offset kept"); // R6
    end

    for (genvar g = 0; g < N_INT; g++) begin : gen_int
        logic [REG_W-1:0] hi_q, lo_q;
        // Display interrupt pair, plain storage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q <= '0;
                lo_q <= '0;
            end else if (wr && ofs == OFS_W'(int'(INT_BASE) + 4*g)) hi_q <= op_i.wdata;
            else if (wr && ofs == OFS_W'(int'(INT_BASE) + 4*g + 2)) lo_q <= op_i.wdata;
        end
        assign int_hi_w[g] = hi_q;
        assign int_lo_w[g] = lo_q;
    end

    for (genvar g = 0; g < N_PLAIN; g++) begin : gen_plain
        logic [REG_W-1:0] q;
        // General-purpose halfword storage.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else if (wr && ofs == OFS_W'(int'(PLAIN_BASE) + 2*g)) q <= op_i.wdata;
        end
        assign plain_w[g] = q;
    end

    // Detect a write to any interrupt upper half.
    always_comb begin
        int_hi_wr = 1'b0;
        for (int k = 0; k < N_INT; k++)
            if (wr && ofs == OFS_W'(int'(INT_BASE) + 4*k)) int_hi_wr = 1'b1;
    end

    // Register the one-cycle interrupt update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_update_o <= 1'b0;
        else        irq_update_o <= int_hi_wr;
    end

    // Read decode; unmapped offsets return zero with no hit.
    always_comb begin
        rd_data_o = '0;
        rd_hit_o  = 1'b0;
        if (ofs == CTRL_OFS)  begin rd_data_o = ctrl_q;   rd_hit_o = 1'b1; end
        if (ofs == VBEAM_OFS) begin rd_data_o = beam_v_i; rd_hit_o = 1'b1; end
        if (ofs == HBEAM_OFS) begin rd_data_o = beam_h_i; rd_hit_o = 1'b1; end
        if (ofs == WIDE_OFS)  begin rd_data_o = wide_q[2*REG_W-1:REG_W]; rd_hit_o = 1'b1; end
        if (ofs == WIDE_OFS + OFS_W'(2)) begin rd_data_o = wide_q[REG_W-1:0]; rd_hit_o = 1'b1; end
        for (int k = 0; k < N_FB; k++) begin
            if (ofs == OFS_W'(int'(FB_BASE) + 4*k))     begin rd_data_o = fb_hi_w[k]; rd_hit_o = 1'b1; end
            if (ofs == OFS_W'(int'(FB_BASE) + 4*k + 2)) begin rd_data_o = fb_lo_w[k]; rd_hit_o = 1'b1; end
        end
        for (int k = 0; k < N_INT; k++) begin
            if (ofs == OFS_W'(int'(INT_BASE) + 4*k))     begin rd_data_o = int_hi_w[k]; rd_hit_o = 1'b1; end
            if (ofs == OFS_W'(int'(INT_BASE) + 4*k + 2)) begin rd_data_o = int_lo_w[k]; rd_hit_o = 1'b1; end
        end
        for (int k = 0; k < N_PLAIN; k++)
            if (ofs == OFS_W'(int'(PLAIN_BASE) + 2*k)) begin rd_data_o = plain_w[k]; rd_hit_o = 1'b1; end
    end

    AST_CTRL_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_WMASK) == '0) else $error("ctrl fixed bits"); // R9
    AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_update_o |-> $past(wr)) else $error("strobe without write"); // R7
endmodule

// File: rtl/hwreg_bank.sv
// Top of the mixed-width register bank: the sequencer feeds halfword
// operations to the store and returns the response. Assumes one request
// outstanding at a time.
module hwreg_bank
    import hwreg_pkg::*;
#(
    parameter int N_PLAIN = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [2:0]  req_size,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [15:0] beam_v,
    input  logic [15:0] beam_h,
    output logic        rsp_ready,
    output logic [31:0] rsp_rdata,
    output logic        rsp_err,
    output logic        irq_update
);
    hw_op_t           op;
    logic [REG_W-1:0] rd_data;
    logic             rd_hit;

    hwreg_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_size_i(req_size),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rd_data_i(rd_data), .rd_hit_i(rd_hit), .op_o(op),
        .rsp_ready_o(rsp_ready), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err)
    );

    hwreg_store #(.N_PLAIN(N_PLAIN)) u_store (
        .clk(clk), .rst_n(rst_n), .op_i(op),
        .beam_v_i(beam_v), .beam_h_i(beam_h),
        .rd_data_o(rd_data), .rd_hit_o(rd_hit), .irq_update_o(irq_update)
    );
endmodule

// File: tb/hwreg_bank_test.sv
`timescale 1ns/1ps
module hwreg_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_size = 3'd2;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [15:0] beam_v = '0, beam_h = '0;
    logic        rsp_ready, rsp_err, irq_update;
    logic [31:0] rsp_rdata;

    int checks = 0, fails = 0, irq_cnt = 0;
    bit done = 0;

    logic        chk_q[$];
    logic [31:0] dat_q[$];
    logic        err_q[$];
    string       tag_q[$];

    hwreg_bank uut (.*);

    always #10 clk = ~clk;

    task automatic check(input string tg, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tg, act, exp);
        end
    endtask

    // Monitor: pop one expected item per completion and compare.
    always @(negedge clk) begin
        if (rst_n && rsp_ready) begin
            if (chk_q.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
            else begin
                logic c; logic [31:0] d; logic e; string t;
                c = chk_q.pop_front(); d = dat_q.pop_front();
                e = err_q.pop_front(); t = tag_q.pop_front();
                if (c) begin
                    check({t, " data"}, rsp_rdata, d);
                    check({t, " err"}, {31'd0, rsp_err}, {31'd0, e});
                end
            end
        end
        if (rst_n && irq_update) irq_cnt++;
    end

    // Driver: push the expectation, present the request for one cycle, wait for completion.
    task automatic bus(input logic wr, input logic [2:0] sz, input logic [31:0] a,
                       input logic [31:0] d, input logic c, input logic [31:0] ed,
                       input logic ee, input string tg);
        chk_q.push_back(c); dat_q.push_back(ed); err_q.push_back(ee); tag_q.push_back(tg);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_ready) @(negedge clk);
    endtask

    task automatic wr16(input logic [31:0] a, input logic [15:0] d);
        bus(1'b1, 3'd2, a, {16'd0, d}, 1'b0, '0, 1'b0, "write");
    endtask
    task automatic rd16(input logic [31:0] a, input logic [15:0] e, input string tg);
        bus(1'b0, 3'd2, a, '0, 1'b1, {16'd0, e}, 1'b0, tg);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1;
        check("R1 ready after reset", {31'd0, rsp_ready}, 32'd0);
        check("R1 irq after reset", {31'd0, irq_update}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        rd16(32'h050, 16'h0000, "R1 plain reset");
        rd16(32'h040, 16'h0000, "R1 wide reset");
        rd16(32'h010, 16'h0000, "R1 fb reset");

        wr16(32'h050, 16'hA5C3);
        rd16(32'h050, 16'hA5C3, "R2 plain0");
        wr16(32'h05E, 16'h1234);
        rd16(32'h05E, 16'h1234, "R2 plain7");

        bus(1'b1, 3'd4, 32'h054, 32'hDEADBEEF, 1'b0, '0, 1'b0, "write");
        rd16(32'h054, 16'hDEAD, "R3 upper half");
        rd16(32'h056, 16'hBEEF, "R3 lower half");
        bus(1'b0, 3'd4, 32'h054, '0, 1'b1, 32'hDEADBEEF, 1'b0, "R3 word read");

        bus(1'b0, 3'd1, 32'h054, '0, 1'b1, 32'h000000DE, 1'b0, "R4 even byte");
        bus(1'b0, 3'd1, 32'h055, '0, 1'b1, 32'h000000AD, 1'b0, "R4 odd byte");
        bus(1'b0, 3'd1, 32'h057, '0, 1'b1, 32'h000000EF, 1'b0, "R4 odd byte lower");

        bus(1'b1, 3'd1, 32'h050, 32'hFF, 1'b1, 32'h0, 1'b0, "R5 byte write completes");
        bus(1'b1, 3'd1, 32'h051, 32'hFF, 1'b0, '0, 1'b0, "write");
        rd16(32'h050, 16'hA5C3, "R5 byte write ignored");

        wr16(32'h010, 16'h1F23);
        rd16(32'h010, 16'h1023, "R6 clear flag set");
        wr16(32'h018, 16'h0F23);
        rd16(32'h018, 16'h0F23, "R6 clear flag clear");
        wr16(32'h01C, 16'hFFFF);
        rd16(32'h01C, 16'hF0FF, "R6 fb3 all ones");
        wr16(32'h012, 16'h0F00);
        rd16(32'h012, 16'h0F00, "R6 lower half plain");

        base = irq_cnt;
        bus(1'b1, 3'd4, 32'h020, 32'h8001_0042, 1'b0, '0, 1'b0, "write");
        @(negedge clk);
        check("R7 one pulse on upper write", irq_cnt - base, 1);
        rd16(32'h020, 16'h8001, "R7 int upper stored");
        rd16(32'h022, 16'h0042, "R7 int lower stored");
        base = irq_cnt;
        wr16(32'h02E, 16'h7777);
        @(negedge clk);
        check("R7 no pulse on lower write", irq_cnt - base, 0);
        wr16(32'h02C, 16'h0001);
        @(negedge clk);
        check("R7 pulse on int3 upper", irq_cnt - base, 1);

        beam_v = 16'h0123; beam_h = 16'h0ABC;
        rd16(32'h030, 16'h0123, "R8 vertical beam");
        wr16(32'h030, 16'hFFFF);
        wr16(32'h032, 16'hFFFF);
        rd16(32'h030, 16'h0123, "R8 vertical write ignored");
        rd16(32'h032, 16'h0ABC, "R8 horizontal beam");
        beam_v = 16'h0456;
        rd16(32'h030, 16'h0456, "R8 follows input");

        wr16(32'h000, 16'hFFFF);
        rd16(32'h000, 16'h030D, "R9 ctrl mask");
        wr16(32'h000, 16'h0104);
        rd16(32'h000, 16'h0104, "R9 ctrl rewrite");

        bus(1'b1, 3'd4, 32'h040, 32'h11223344, 1'b0, '0, 1'b0, "write");
        wr16(32'h042, 16'hAAAA);
        bus(1'b0, 3'd4, 32'h040, '0, 1'b1, 32'h1122AAAA, 1'b0, "R10 lower merge");
        wr16(32'h040, 16'h5555);
        bus(1'b0, 3'd4, 32'h040, '0, 1'b1, 32'h5555AAAA, 1'b0, "R10 upper merge");

        bus(1'b0, 3'd2, 32'h100, '0, 1'b1, 32'h0, 1'b1, "R11 unmapped read");
        wr16(32'h100, 16'hFFFF);
        bus(1'b0, 3'd2, 32'h100, '0, 1'b1, 32'h0, 1'b1, "R11 unmapped write dropped");
        bus(1'b0, 3'd1, 32'h101, '0, 1'b1, 32'h0, 1'b1, "R11 unmapped byte");
        rd16(32'h050, 16'hA5C3, "R11 mapped no error");

        rd16(32'hCC00_2050, 16'hA5C3, "R12 window base alias");
        wr16(32'h7000_1052, 16'h7777);
        rd16(32'h052, 16'h7777, "R12 alias write");

        repeat (2) @(negedge clk);
        check("scoreboard drained", chk_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule